// File: doc/BRIEF.md
# Time-Multiplexed Inter-Chip Signal Scheduler

In a logic emulator built from many chips, each chip has far fewer pins than the partition it holds needs. This block lets one physical pin carry several logical signals in turn. A start pulse at each emulation clock edge launches a one-hot sequencer, which walks a fixed number of microclock cycles (microcycles) and then raises a done flag. A schedule fixed at compile time decides which local signal each outgoing pin drives in each microcycle. It also decides in which microcycle and on which incoming pin each virtual-signal register takes its bit.

A relay path carries bits that only pass through this chip on their way elsewhere. Incoming pin 0 is sampled every active microcycle, and the sample is driven out on pin 0 in the final microcycle. A through-hop transfer therefore takes two communication microcycles. Any slot that the schedule leaves empty drives logic 0.

The default schedule has three transmit microcycles that send out the local outputs in pairs. A fourth microcycle is reserved for the relayed bit. Receive capture happens in microcycles 0 and 1.

Top module: `vw_link_sched`

## Requirements
- R1: While reset is asserted and right after it, `pin_o`, `virt_o` and `done_o` are all zero.
- R2: A start pulse sampled on a clock edge makes the next cycle microcycle 0. Each later clock edge advances one microcycle, through microcycle N_UCYC-1 (4 in total by default).
- R3: In microcycle m < N_UCYC-1, output pin p drives `local_i[(m*N_PIN+p) % N_LOCAL]`. By default that is `local_i[2m]` on pin 0 and `local_i[2m+1]` on pin 1.
- R4: In the last microcycle, pin 0 drives the value that `pin_i[0]` had in the microcycle before it (through-hop relay).
- R5: Slots with no schedule entry drive 0. This covers pin 1 in the last microcycle and every pin while the sequencer is idle.
- R6: Virtual register v takes `pin_i[v % N_IN]` at the end of microcycle `v / N_IN`. By default, microcycle 0 loads v0 from pin 0 and v1 from pin 1, and microcycle 1 loads v2 and v3 the same way.
- R7: A virtual register keeps its value outside its own slot. Pin inputs during idle cycles or in other microcycles have no effect on it.
- R8: `done_o` rises on the clock edge that ends the last microcycle. It stays high while the sequencer is idle and clears on the edge that takes a start pulse.
- R9: A start pulse during a run abandons the run, and the next cycle is microcycle 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Microclock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_start_i | input | 1 | One-cycle pulse at the emulation clock edge |
| local_i | input | N_LOCAL (6) | Local logical signals to send |
| pin_i | input | N_IN (2) | Incoming physical pins |
| pin_o | output | N_PIN (2) | Outgoing physical pins |
| virt_o | output | N_VIRT (4) | Received virtual-signal registers |
| done_o | output | 1 | All microcycles of this emulation period are finished |

## Verification
Four vectors run through a full period each. Local words with alternating, all-one and all-zero bits show whether each pin picks the right local index in each microcycle. Pin patterns that differ between microcycles 0, 1 and 2 show whether each virtual register takes its bit in its own slot and not a neighbour's. They also show whether the relayed bit comes from microcycle 2 rather than from a capture slot. Directed runs cover idle pin toggling, the relay and empty-slot zeros, and a restart in the middle of a period. The local word for the restart differs in every microcycle, so the bench can tell which microcycle the sequencer landed on.

// File: rtl/vw_sched_pkg.sv
package vw_sched_pkg;

  // one transmit slot: pin driven by a local signal or by the relay register
  typedef struct packed {
    logic valid;
    logic relay;
    int   idx;
  } tx_slot_t;

  // capture slot of one virtual register
  typedef struct packed {
    logic valid;
    int   ucyc;
    int   pin;
  } rx_slot_t;

  function automatic tx_slot_t tx_slot(int m, int p, int n_ucyc, int n_pin, int n_local);
    tx_slot_t s;
    s.valid = 1'b0;
    s.relay = 1'b0;
    s.idx   = 0;
    if (m < n_ucyc - 1) begin
      s.valid = 1'b1;
      s.idx   = (m * n_pin + p) % n_local;
    end else if (p == 0) begin
      s.valid = 1'b1;
      s.relay = 1'b1;
    end
    return s;
  endfunction

  function automatic rx_slot_t rx_slot(int v, int n_in, int n_ucyc);
    rx_slot_t s;
    s.ucyc  = v / n_in;
    s.pin   = v % n_in;
    s.valid = (v / n_in) < n_ucyc;
    return s;
  endfunction

endpackage

// File: rtl/vw_ucyc_seq.sv
module vw_ucyc_seq #(
  parameter int N_UCYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [N_UCYC-1:0] ucyc_o,
  output logic              done_o
);

  logic [N_UCYC-1:0] ucyc_q, ucyc_d;
  logic              done_q, done_d;
  logic              seq_en;

  assign seq_en = start_i | (|ucyc_q);

  always_comb begin
    ucyc_d = ucyc_q;
    done_d = done_q;
    if (start_i) begin
      ucyc_d = {{(N_UCYC-1){1'b0}}, 1'b1};
      done_d = 1'b0;
    end else if (ucyc_q[N_UCYC-1]) begin
      ucyc_d = '0;
      done_d = 1'b1;
    end else begin
      ucyc_d = ucyc_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucyc_q <= '0;
      done_q <= 1'b0;
    end else if (seq_en) begin
      ucyc_q <= ucyc_d;
      done_q <= done_d;
    end
  end

  assign ucyc_o = ucyc_q;
  assign done_o = done_q;

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ucyc_q)); // R2
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && (|ucyc_q) && !ucyc_q[N_UCYC-1]) |=> (ucyc_q == ($past(ucyc_q) << 1))); // R2
  AST_START_M0: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ucyc_q[0] && !done_q)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ucyc_q == '0)); // R8

endmodule

// File: rtl/vw_tx_mux.sv
module vw_tx_mux #(
  parameter int N_UCYC  = 4,
  parameter int N_PIN   = 2,
  parameter int N_LOCAL = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UCYC-1:0]  ucyc_i,
  input  logic [N_LOCAL-1:0] local_i,
  input  logic               relay_i,
  output logic [N_PIN-1:0]   pin_o
);

  logic [N_PIN-1:0] term [N_UCYC];

  for (genvar m = 0; m < N_UCYC; m++) begin : g_ucyc
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      localparam vw_sched_pkg::tx_slot_t SLOT =
        vw_sched_pkg::tx_slot(m, p, N_UCYC, N_PIN, N_LOCAL);
      if (!SLOT.valid) begin : g_empty
        assign term[m][p] = 1'b0;
      end else if (SLOT.relay) begin : g_relay
        assign term[m][p] = ucyc_i[m] & relay_i;
      end else begin : g_local
        assign term[m][p] = ucyc_i[m] & local_i[SLOT.idx];
      end
    end
  end

  always_comb begin
    pin_o = '0;
    for (int m = 0; m < N_UCYC; m++) begin
      pin_o = pin_o | term[m];
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ucyc_i == '0) |-> (pin_o == '0)); // R5

endmodule

// File: rtl/vw_rx_cap.sv
module vw_rx_cap #(
  parameter int N_UCYC = 4,
  parameter int N_IN   = 2,
  parameter int N_VIRT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_UCYC-1:0] ucyc_i,
  input  logic [N_IN-1:0]   pin_i,
  output logic              relay_o,
  output logic [N_VIRT-1:0] virt_o
);

  logic [N_VIRT-1:0] cap_en, cap_d;
  logic [N_VIRT-1:0] virt_q;
  logic              relay_q;
  logic              busy;

  assign busy = |ucyc_i;

  for (genvar v = 0; v < N_VIRT; v++) begin : g_virt
    localparam vw_sched_pkg::rx_slot_t SLOT = vw_sched_pkg::rx_slot(v, N_IN, N_UCYC);
    if (SLOT.valid) begin : g_slot
      assign cap_en[v] = ucyc_i[SLOT.ucyc];
      assign cap_d[v]  = pin_i[SLOT.pin];
    end else begin : g_none
      assign cap_en[v] = 1'b0;
      assign cap_d[v]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      virt_q <= '0;
    end else if (|cap_en) begin
      virt_q <= (virt_q & ~cap_en) | (cap_d & cap_en);
    end
  end

  // relay register: one microcycle of delay gives the through-hop slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      relay_q <= 1'b0;
    end else if (busy) begin
      relay_q <= pin_i[0];
    end
  end

  assign relay_o = relay_q;
  assign virt_o  = virt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(virt_q)); // R7

endmodule

// File: rtl/vw_link_sched.sv
module vw_link_sched #(
  parameter int N_UCYC  = 4,
  parameter int N_PIN   = 2,
  parameter int N_IN    = 2,
  parameter int N_LOCAL = 6,
  parameter int N_VIRT  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               emu_start_i,
  input  logic [N_LOCAL-1:0] local_i,
  input  logic [N_IN-1:0]    pin_i,
  output logic [N_PIN-1:0]   pin_o,
  output logic [N_VIRT-1:0]  virt_o,
  output logic               done_o
);

  logic [N_UCYC-1:0] ucyc;
  logic              relay;

  vw_ucyc_seq #(.N_UCYC(N_UCYC)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (emu_start_i),
    .ucyc_o  (ucyc),
    .done_o  (done_o)
  );

  vw_tx_mux #(.N_UCYC(N_UCYC), .N_PIN(N_PIN), .N_LOCAL(N_LOCAL)) i_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .ucyc_i  (ucyc),
    .local_i (local_i),
    .relay_i (relay),
    .pin_o   (pin_o)
  );

  vw_rx_cap #(.N_UCYC(N_UCYC), .N_IN(N_IN), .N_VIRT(N_VIRT)) i_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .ucyc_i  (ucyc),
    .pin_i   (pin_i),
    .relay_o (relay),
    .virt_o  (virt_o)
  );

endmodule

// File: tb/test_vw_link_sched.sv
module test_vw_link_sched;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic [5:0] loc;
    logic [7:0] pins;   // {m3, m2, m1, m0}, each {pin1, pin0}
    logic [3:0] virt;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{6'h25, 8'b01_00_10_01, 4'b1001},
    '{6'h3C, 8'b00_01_11_10, 4'b1110},
    '{6'h3F, 8'hFF,          4'b1111},
    '{6'h00, 8'h00,          4'b0000}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [5:0] loc;
  logic [1:0] pin_in;
  logic [1:0] pin_out;
  logic [3:0] virt;
  logic       done;
  int n_run  = 0;
  int n_fail = 0;

  vw_link_sched i_vw_link_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .emu_start_i (start),
    .local_i     (loc),
    .pin_i       (pin_in),
    .pin_o       (pin_out),
    .virt_o      (virt),
    .done_o      (done)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; loc = '0; pin_in = '0;
    repeat (2) @(negedge clk);
    check("R1 pin_o", 8'(pin_out), 8'h0);
    check("R1 virt", 8'(virt), 8'h0);
    check("R1 done", 8'(done), 8'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after release", 8'(done), 8'h0);

    // vector table: one full emulation period each
    for (int k = 0; k < 4; k++) begin
      loc = VECS[k].loc; start = 1'b1; pin_in = '0;
      @(negedge clk);
      start = 1'b0;
      for (int m = 0; m < 4; m++) begin
        logic [1:0] exp_pin;
        pin_in = VECS[k].pins[2*m +: 2];
        if (m < 3) exp_pin = {VECS[k].loc[2*m+1], VECS[k].loc[2*m]};  // R3
        else       exp_pin = {1'b0, VECS[k].pins[4]};                  // R4, R5
        #1;
        check(m < 3 ? "R3 tx slot" : "R4 relay/R5 empty", 8'(pin_out), 8'(exp_pin));
        if (m == 0) check("R8 done cleared", 8'(done), 8'h0);
        @(negedge clk);
      end
      check("R6 capture", 8'(virt), 8'(VECS[k].virt));
      check("R8 done set", 8'(done), 8'h1);
      check("R5 idle zero", 8'(pin_out), 8'h0);
    end

    // R7: pin toggles while idle leave registers alone
    for (int c = 0; c < 3; c++) begin
      pin_in = (c % 2 == 0) ? 2'b11 : 2'b01;
      @(negedge clk);
      check("R7 idle hold", 8'(virt), 8'h0);
      check("R5 idle pins", 8'(pin_out), 8'h0);
    end
    check("R8 done held", 8'(done), 8'h1);

    // R2 and R9: restart from microcycle 1
    loc = 6'h1B; start = 1'b1; pin_in = 2'b00;
    @(negedge clk);
    start = 1'b0;
    #1 check("R2 m0", 8'(pin_out), 8'h3);
    @(negedge clk);
    #1 check("R2 m1", 8'(pin_out), 8'h2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1 check("R9 restart m0", 8'(pin_out), 8'h3);
    check("R9 done low", 8'(done), 8'h0);
    pin_in = 2'b10;
    @(negedge clk);
    pin_in = 2'b01;
    #1 check("R2 m1 again", 8'(pin_out), 8'h2);
    @(negedge clk);
    pin_in = 2'b11;
    #1 check("R2 m2", 8'(pin_out), 8'h1);
    @(negedge clk);
    pin_in = 2'b00;
    #1 check("R4 relay of m2", 8'(pin_out), 8'h1);
    check("R7 no late capture", 8'(virt), 8'b0110);
    @(negedge clk);
    check("R7 final virt", 8'(virt), 8'b0110);
    check("R8 done end", 8'(done), 8'h1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule